// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block sits between a simple host request port and the command pins of a single-rank SDRAM. It accepts one read or write request at a time, naming a bank, a row, a column and whether auto-precharge is wanted. For each request it opens the row, issues the column command, and then closes the row again, either with an explicit single-bank precharge or by letting the memory precharge itself. Every spacing between commands is counted in clock cycles from parameters: row-to-column delay, row active time, precharge time, row cycle time, write recovery and mode-register settling.

After reset the sequencer runs the power-up routine by itself. It waits a parameterised number of cycles, precharges all banks, issues two auto refreshes and loads the mode register. A refresh interval timer then raises a refresh request every `T_REFI` cycles. A pending refresh wins over a waiting host request once the access in flight has closed its row. The sequencer precharges all banks before each auto refresh. In every cycle where no command is due, the pins carry a NOP.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Pins are encoded as {cs_n,ras_n,cas_n,we_n}: NOP 0111, activate 0011, read 0101, write 0100, precharge 0010, auto refresh 0001, mode register set 0000. During and after reset the pins show NOP while no command is due, cke is 1, and init_done and req_ack are 0 until set.
- R2: After reset and `T_INIT` cycles, the power-up sequence is issued in this order: precharge with address bit 10 high (all banks), auto refresh, auto refresh, then mode register set carrying `MODE_WORD` on the address with bank 0. init_done reads 1 from the mode register set cycle onward.
- R3: No command follows a mode register set in fewer than `T_MRD` cycles. A host request already waiting gets its activate exactly `T_MRD` cycles after the mode register set.
- R4: An activate carries the request's bank and its row on the full address. The read or write follows exactly `T_RCD` cycles later, with the same bank, the column on address bits [COL_W-1:0] and address bit 10 equal to the auto-precharge flag.
- R5: req_ack is high for exactly one cycle per request, the cycle in which that request's read or write appears on the pins.
- R6: Without auto-precharge, the row is closed by a precharge with bit 10 low and the request's bank. It comes at the later of `T_RAS` cycles after the activate and, after a write, `T_WR` cycles after the write, or 1 cycle after a read.
- R7: With auto-precharge, no explicit precharge is issued for the access. The next activate waits until the implicit precharge point (the later of `T_RAS` after the activate and the write recovery) plus `T_RP`.
- R8: No activate or auto refresh comes less than `T_RP` cycles after any precharge, whether explicit or implicit.
- R9: No activate or auto refresh comes less than `T_RC` cycles after the previous activate or auto refresh. The auto-refresh cycle time is the same `T_RC`.
- R10: After initialisation, an idle sequencer issues an auto refresh every `T_REFI` cycles. Each refresh is preceded, `T_RP` cycles earlier, by a precharge with bit 10 high.
- R11: A pending refresh takes priority over a host request once the current access has closed. Refreshes still occur while the host keeps req_valid high without a break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present; hold until req_ack |
| req_we | input | 1 | 1 = write, 0 = read |
| req_ap | input | 1 | 1 = column command with auto-precharge |
| req_ba | input | BA_W | Bank of the request |
| req_row | input | ADDR_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| req_ack | output | 1 | One-cycle pulse when the read/write is issued |
| init_done | output | 1 | Power-up sequence finished |
| cke | output | 1 | Clock enable, held high |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Multiplexed row/column/mode address, bit 10 = auto-precharge / all banks |
| sd_ba | output | BA_W | Bank address |

## Verification
Saturating "cycles since" counters watch the pins. On every cycle the assertions check the minimum spacings: mode settle, row-to-column, row active, write recovery, precharge, row cycle. They also check that an acknowledge only ever coincides with a column command and that every refresh directly follows a precharge-all. Only the scenarios can show that spacings are exact rather than merely sufficient, that the right bank, row, column and flag reach the address pins, that the refresh period equals `T_REFI`, and that refresh is not starved under a saturating host.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // pin encoding {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_REF   = 4'b0001,
    CMD_PRE   = 4'b0010,
    CMD_ACT   = 4'b0011,
    CMD_WR    = 4'b0100,
    CMD_RD    = 4'b0101,
    CMD_BST   = 4'b0110,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } cmd_e;

  typedef enum logic [3:0] {
    ST_PWR, ST_IREF1, ST_IREF2, ST_IMRS,
    ST_IDLE, ST_ROW, ST_CLOSE, ST_REF
  } seq_st_e;

  localparam int SINCE_W = 8;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // saturating "cycles since" increment used by the checkers
  function automatic logic [SINCE_W-1:0] sat_inc(input logic [SINCE_W-1:0] v);
    return (v == '1) ? v : v + 1'b1;
  endfunction

endpackage

// File: rtl/seq_delay_cnt.sv
module seq_delay_cnt #(
  parameter int W = 4,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  assign zero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= RST_VAL;
    else if (load)  cnt <= load_val;
    else if (!zero) cnt <= cnt - 1'b1;
  end

endmodule

// File: rtl/seq_refresh_timer.sv
module seq_refresh_timer #(
  parameter int T_REFI = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic served,
  output logic pending
);
  localparam int TW = $clog2(T_REFI + 1);
  localparam logic [TW-1:0] LAST = TW'(T_REFI - 1);

  logic [TW-1:0] cnt;
  logic          tick;

  assign tick = en && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (en) cnt <= tick ? '0 : cnt + 1'b1;
      if (tick)        pending <= 1'b1;
      else if (served) pending <= 1'b0;
    end
  end

  // R10: a refresh request stays until it is served
  p_pending_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !served |=> pending);

  // R10: serving clears the request unless a new interval just ended
  p_pending_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    served && !tick |=> !pending);

endmodule

// File: rtl/seq_cmd_out.sv
module seq_cmd_out
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_e              cmd_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic [BA_W-1:0]   ba_d,
  input  logic              ack_d,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BA_W-1:0]   ba,
  output logic              ack
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {cs_n, ras_n, cas_n, we_n} <= CMD_NOP;
      addr <= '0;
      ba   <= '0;
      ack  <= 1'b0;
    end else begin
      {cs_n, ras_n, cas_n, we_n} <= cmd_d;
      addr <= addr_d;
      ba   <= ba_d;
      ack  <= ack_d;
    end
  end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
  import sdram_seq_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int BA_W     = 2,
  parameter int COL_W    = 10,
  parameter int AP_BIT   = 10,
  parameter int T_INIT   = 100,
  parameter int T_RCD    = 3,
  parameter int T_RAS    = 5,
  parameter int T_RC     = 8,
  parameter int T_RP     = 3,
  parameter int T_WR     = 2,
  parameter int T_MRD    = 2,
  parameter int T_REFI   = 780,
  parameter logic [ADDR_W-1:0] MODE_WORD = 13'h020
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic              req_ap,
  input  logic [BA_W-1:0]   req_ba,
  input  logic [ADDR_W-1:0] req_row,
  input  logic [COL_W-1:0]  req_col,
  output logic              req_ack,
  output logic              init_done,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [BA_W-1:0]   sd_ba
);
  localparam int TMAX = imax(imax(imax(T_INIT, T_RC), imax(T_RAS, T_RCD)),
                             imax(imax(T_RP, T_WR), T_MRD));
  localparam int CW = $clog2(TMAX + 1);
  localparam logic [CW-1:0] L_INIT = CW'(T_INIT - 1);
  localparam logic [CW-1:0] L_RCD  = CW'(T_RCD - 1);
  localparam logic [CW-1:0] L_RAS  = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RC   = CW'(T_RC - 1);
  localparam logic [CW-1:0] L_RP   = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_WR   = CW'(T_WR - 1);
  localparam logic [CW-1:0] L_MRD  = CW'(T_MRD - 1);

  // column word: column in the low bits, bit AP_BIT carries the flag
  function automatic logic [ADDR_W-1:0] col_word(input logic [COL_W-1:0] c,
                                                 input logic ap);
    logic [ADDR_W-1:0] w;
    w = '0;
    w[COL_W-1:0] = c;
    w[AP_BIT] = ap;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] all_banks_word();
    logic [ADDR_W-1:0] w;
    w = '0;
    w[AP_BIT] = 1'b1;
    return w;
  endfunction

  // ---------------- state and request latch ----------------
  seq_st_e st_q, st_d;
  logic              lat_we, lat_ap;
  logic [BA_W-1:0]   lat_ba;
  logic [COL_W-1:0]  lat_col;
  logic              init_q;
  logic              apc_q;

  // ---------------- next-command decision ----------------
  cmd_e              cmd_d;
  logic [ADDR_W-1:0] addr_d;
  logic [BA_W-1:0]   ba_d;
  logic              ack_d, apc_d;
  logic              wait_ld, ras_ld, rc_ld;
  logic [CW-1:0]     wait_val;
  logic              ref_served;
  logic              wait_z, ras_z, rc_z, ref_pend;

  // named events for the checkers
  logic ev_act_issue, ev_rw_issue, ev_ref_issue;
  assign ev_act_issue = (cmd_d == CMD_ACT);
  assign ev_rw_issue  = (cmd_d == CMD_RD) || (cmd_d == CMD_WR);
  assign ev_ref_issue = (cmd_d == CMD_REF);

  always_comb begin
    st_d       = st_q;
    cmd_d      = CMD_NOP;
    addr_d     = '0;
    ba_d       = '0;
    ack_d      = 1'b0;
    apc_d      = 1'b0;
    wait_ld    = 1'b0;
    wait_val   = '0;
    ras_ld     = 1'b0;
    rc_ld      = 1'b0;
    ref_served = 1'b0;
    unique case (st_q)
      ST_PWR: if (wait_z) begin
        cmd_d    = CMD_PRE;
        addr_d   = all_banks_word();
        wait_ld  = 1'b1;
        wait_val = L_RP;
        st_d     = ST_IREF1;
      end
      ST_IREF1, ST_IREF2: if (wait_z && rc_z) begin
        cmd_d    = CMD_REF;
        wait_ld  = 1'b1;
        wait_val = L_RC;
        rc_ld    = 1'b1;
        st_d     = (st_q == ST_IREF1) ? ST_IREF2 : ST_IMRS;
      end
      ST_IMRS: if (wait_z && rc_z) begin
        cmd_d    = CMD_MRS;
        addr_d   = MODE_WORD;
        wait_ld  = 1'b1;
        wait_val = L_MRD;
        st_d     = ST_IDLE;
      end
      ST_IDLE: begin
        if (ref_pend) begin
          if (wait_z && ras_z) begin
            cmd_d    = CMD_PRE;
            addr_d   = all_banks_word();
            wait_ld  = 1'b1;
            wait_val = L_RP;
            st_d     = ST_REF;
          end
        end else if (req_valid && wait_z && rc_z) begin
          cmd_d    = CMD_ACT;
          addr_d   = req_row;
          ba_d     = req_ba;
          wait_ld  = 1'b1;
          wait_val = L_RCD;
          ras_ld   = 1'b1;
          rc_ld    = 1'b1;
          st_d     = ST_ROW;
        end
      end
      ST_ROW: if (wait_z) begin
        cmd_d    = lat_we ? CMD_WR : CMD_RD;
        addr_d   = col_word(lat_col, lat_ap);
        ba_d     = lat_ba;
        ack_d    = 1'b1;
        wait_ld  = 1'b1;
        wait_val = lat_we ? L_WR : '0;
        st_d     = ST_CLOSE;
      end
      ST_CLOSE: if (wait_z && ras_z) begin
        if (lat_ap) begin
          apc_d = 1'b1;
        end else begin
          cmd_d = CMD_PRE;
          ba_d  = lat_ba;
        end
        wait_ld  = 1'b1;
        wait_val = L_RP;
        st_d     = ST_IDLE;
      end
      ST_REF: if (wait_z && rc_z) begin
        cmd_d      = CMD_REF;
        wait_ld    = 1'b1;
        wait_val   = L_RC;
        rc_ld      = 1'b1;
        ref_served = 1'b1;
        st_d       = ST_IDLE;
      end
      default: st_d = ST_PWR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_PWR;
      lat_we  <= 1'b0;
      lat_ap  <= 1'b0;
      lat_ba  <= '0;
      lat_col <= '0;
      init_q  <= 1'b0;
      apc_q   <= 1'b0;
    end else begin
      st_q  <= st_d;
      apc_q <= apc_d;
      if (cmd_d == CMD_MRS) init_q <= 1'b1;
      if (ev_act_issue) begin
        lat_we  <= req_we;
        lat_ap  <= req_ap;
        lat_ba  <= req_ba;
        lat_col <= req_col;
      end
    end
  end

  assign init_done = init_q;
  assign cke       = 1'b1;

  // ---------------- timing counters ----------------
  seq_delay_cnt #(.W(CW), .RST_VAL(L_INIT)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(wait_ld), .load_val(wait_val), .zero(wait_z));

  seq_delay_cnt #(.W(CW), .RST_VAL('0)) u_ras (
    .clk(clk), .rst_n(rst_n), .load(ras_ld), .load_val(L_RAS), .zero(ras_z));

  seq_delay_cnt #(.W(CW), .RST_VAL('0)) u_rc (
    .clk(clk), .rst_n(rst_n), .load(rc_ld), .load_val(L_RC), .zero(rc_z));

  seq_refresh_timer #(.T_REFI(T_REFI)) u_refi (
    .clk(clk), .rst_n(rst_n), .en(init_q), .served(ref_served), .pending(ref_pend));

  seq_cmd_out #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .cmd_d(cmd_d), .addr_d(addr_d), .ba_d(ba_d),
    .ack_d(ack_d), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .addr(sd_addr), .ba(sd_ba), .ack(req_ack));

  // ---------------- pin-side checkers ----------------
  localparam logic [SINCE_W-1:0] S_RCD = SINCE_W'(T_RCD);
  localparam logic [SINCE_W-1:0] S_RAS = SINCE_W'(T_RAS);
  localparam logic [SINCE_W-1:0] S_RC  = SINCE_W'(T_RC);
  localparam logic [SINCE_W-1:0] S_RP  = SINCE_W'(T_RP);
  localparam logic [SINCE_W-1:0] S_WR  = SINCE_W'(T_WR);
  localparam logic [SINCE_W-1:0] S_MRD = SINCE_W'(T_MRD);

  logic [3:0] pin_cmd;
  logic pin_act, pin_rd, pin_wr, pin_pre, pin_ref, pin_mrs, pin_nop;
  assign pin_cmd = {cs_n, ras_n, cas_n, we_n};
  assign pin_act = (pin_cmd == CMD_ACT);
  assign pin_rd  = (pin_cmd == CMD_RD);
  assign pin_wr  = (pin_cmd == CMD_WR);
  assign pin_pre = (pin_cmd == CMD_PRE);
  assign pin_ref = (pin_cmd == CMD_REF);
  assign pin_mrs = (pin_cmd == CMD_MRS);
  assign pin_nop = (pin_cmd == CMD_NOP);

  logic [SINCE_W-1:0] since_act, since_rc, since_pre, since_wr, since_mrs;
  logic [3:0] last_cmd;
  logic       last_a10;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= '1;
      since_rc  <= '1;
      since_pre <= '1;
      since_wr  <= '1;
      since_mrs <= '1;
      last_cmd  <= CMD_NOP;
      last_a10  <= 1'b0;
    end else begin
      since_act <= pin_act ? SINCE_W'(1) : sat_inc(since_act);
      since_rc  <= (pin_act || pin_ref) ? SINCE_W'(1) : sat_inc(since_rc);
      since_pre <= (pin_pre || apc_q) ? SINCE_W'(1) : sat_inc(since_pre);
      since_wr  <= pin_wr ? SINCE_W'(1) : sat_inc(since_wr);
      since_mrs <= pin_mrs ? SINCE_W'(1) : sat_inc(since_mrs);
      if (!pin_nop) begin
        last_cmd <= pin_cmd;
        last_a10 <= sd_addr[AP_BIT];
      end
    end
  end

  // R2: before init completes only the power-up commands appear
  p_init_cmds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done && !pin_nop |-> (pin_pre || pin_ref || pin_mrs));

  // R3: mode register settle time
  p_mrd_settle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_nop |-> since_mrs >= S_MRD);

  // R4: row-to-column delay
  p_rcd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_rd || pin_wr) |-> since_act >= S_RCD);

  // R5: acknowledge only with a column command
  p_ack_with_rw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> (pin_rd || pin_wr));

  // R6: explicit single-bank precharge respects active time and write recovery
  p_ras_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pre && !sd_addr[AP_BIT] |-> since_act >= S_RAS);
  p_wr_recovery_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pre |-> since_wr >= S_WR);

  // R7: implicit precharge point respects active time and write recovery
  p_autopre_point_r7: assert property (@(posedge clk) disable iff (!rst_n)
    apc_q |-> (since_act >= S_RAS) && (since_wr >= S_WR) && pin_nop);

  // R8: precharge time before activate or refresh
  p_rp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_act || pin_ref) |-> since_pre >= S_RP);

  // R9: row cycle time between activates and refreshes
  p_rc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_act || pin_ref) |-> since_rc >= S_RC);

  // R10: every refresh follows a precharge-all or another refresh
  p_pall_before_ref_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_ref |-> ((last_cmd == CMD_PRE) && last_a10) || (last_cmd == CMD_REF));

endmodule

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;
  import sdram_seq_pkg::*;

  localparam int T_INIT = 10;
  localparam int T_RCD  = 3;
  localparam int T_RAS  = 5;
  localparam int T_RC   = 8;
  localparam int T_RP   = 3;
  localparam int T_WR   = 2;
  localparam int T_MRD  = 2;
  localparam int T_REFI = 150;
  localparam logic [12:0] MODE = 13'h020;
  localparam int LOGN = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_ap = 1'b0;
  logic [1:0]  req_ba = '0;
  logic [12:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_ack, init_done, cke, cs_n, ras_n, cas_n, we_n;
  logic [12:0] sd_addr;
  logic [1:0]  sd_ba;

  always #4 clk = ~clk;

  sdram_cmd_seq #(.T_INIT(T_INIT), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC),
    .T_RP(T_RP), .T_WR(T_WR), .T_MRD(T_MRD), .T_REFI(T_REFI), .MODE_WORD(MODE)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we), .req_ap(req_ap),
    .req_ba(req_ba), .req_row(req_row), .req_col(req_col), .req_ack(req_ack),
    .init_done(init_done), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .sd_addr(sd_addr), .sd_ba(sd_ba));

  typedef struct packed {
    logic        we;
    logic        ap;
    logic [1:0]  ba;
    logic [12:0] row;
    logic [9:0]  col;
    logic [3:0]  exp_rw;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{1'b0, 1'b0, 2'd1, 13'h1abc, 10'h155, 4'b0101},
    '{1'b1, 1'b0, 2'd2, 13'h0003, 10'h2aa, 4'b0100},
    '{1'b0, 1'b1, 2'd3, 13'h1fff, 10'h3ff, 4'b0101},
    '{1'b1, 1'b1, 2'd0, 13'h0800, 10'h001, 4'b0100},
    '{1'b1, 1'b0, 2'd3, 13'h0555, 10'h200, 4'b0100},
    '{1'b0, 1'b0, 2'd0, 13'h0000, 10'h000, 4'b0101}
  };

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [3:0]  lg_cmd  [LOGN];
  logic [12:0] lg_addr [LOGN];
  logic [1:0]  lg_ba   [LOGN];
  int          lg_cyc  [LOGN];
  int lg_n = 0;
  int ack_n = 0;
  int ack_cyc = -1;

  always @(negedge clk) begin
    if (rst_n) begin
      if ({cs_n, ras_n, cas_n, we_n} != 4'b0111 && lg_n < LOGN) begin
        lg_cmd[lg_n]  = {cs_n, ras_n, cas_n, we_n};
        lg_addr[lg_n] = sd_addr;
        lg_ba[lg_n]   = sd_ba;
        lg_cyc[lg_n]  = cyc;
        lg_n++;
      end
      if (req_ack) begin
        ack_n++;
        ack_cyc = cyc;
      end
    end
  end

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int find(input int from, input logic [3:0] c);
    for (int k = from; k < lg_n; k++) if (lg_cmd[k] == c) return k;
    return -1;
  endfunction

  function automatic int exp_gap(input logic we);
    int close;
    close = (T_RAS > T_RCD + (we ? T_WR : 1)) ? T_RAS : T_RCD + (we ? T_WR : 1);
    return (T_RC > close + T_RP) ? T_RC : close + T_RP;
  endfunction

  task automatic drive(input vec_t v);
    req_we = v.we; req_ap = v.ap; req_ba = v.ba; req_row = v.row; req_col = v.col;
    req_valid = 1'b1;
    do @(negedge clk); while (!req_ack);
    req_valid = 1'b0;
  endtask

  task automatic wait_ref();
    int b;
    b = lg_n;
    while (find(b, 4'b0001) < 0) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int a, b, r, n0, nref, nrw;
    // ---- reset state (R1)
    repeat (4) @(negedge clk);
    chk("R1 reset pins NOP", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
    chk("R1 reset cke", cke, 1);
    chk("R1 reset init_done", init_done, 0);
    chk("R1 reset ack", req_ack, 0);
    // first vector waits through init
    req_we = VEC[0].we; req_ap = VEC[0].ap; req_ba = VEC[0].ba;
    req_row = VEC[0].row; req_col = VEC[0].col; req_valid = 1'b1;
    rst_n = 1'b1;

    // ---- vector loop (R4, R5, R6, R7)
    for (int i = 0; i < 6; i++) begin
      int base, n_ack0;
      base = (i == 0) ? 0 : lg_n;
      n_ack0 = ack_n;
      if (i == 0) begin
        do @(negedge clk); while (!req_ack);
        req_valid = 1'b0;
      end else drive(VEC[i]);
      repeat (14) @(negedge clk);
      if (i == 0) begin
        // power-up order and spacing (R2, R3, R8, R9)
        chk("R2 first cmd precharge", lg_cmd[0], 4'b0010);
        chk("R2 precharge-all bit10", lg_addr[0][10], 1);
        chk("R2 refresh one", lg_cmd[1], 4'b0001);
        chk("R8 pall to refresh", lg_cyc[1] - lg_cyc[0], T_RP);
        chk("R2 refresh two", lg_cmd[2], 4'b0001);
        chk("R9 refresh to refresh", lg_cyc[2] - lg_cyc[1], T_RC);
        chk("R2 mode set", lg_cmd[3], 4'b0000);
        chk("R2 mode word", lg_addr[3], MODE);
        chk("R2 mode bank", lg_ba[3], 0);
        chk("R9 refresh to mode set", lg_cyc[3] - lg_cyc[2], T_RC);
        chk("R2 init_done", init_done, 1);
        chk("R3 activate after mode set", lg_cyc[4] - lg_cyc[3], T_MRD);
      end
      a = find(base, 4'b0011);
      chk("R4 activate found", (a >= 0) ? 1 : 0, 1);
      if (a >= 0 && a + 1 < lg_n) begin
        chk("R4 row", lg_addr[a], VEC[i].row);
        chk("R4 act bank", lg_ba[a], VEC[i].ba);
        chk("R4 column cmd", lg_cmd[a + 1], VEC[i].exp_rw);
        chk("R4 rcd", lg_cyc[a + 1] - lg_cyc[a], T_RCD);
        chk("R4 column", lg_addr[a + 1][9:0], VEC[i].col);
        chk("R4 ap flag", lg_addr[a + 1][10], VEC[i].ap);
        chk("R4 rw bank", lg_ba[a + 1], VEC[i].ba);
        chk("R5 ack cycle", ack_cyc, lg_cyc[a + 1]);
        chk("R5 one ack", ack_n - n_ack0, 1);
        if (!VEC[i].ap) begin
          int ex;
          ex = lg_cyc[a] + T_RAS;
          if (lg_cyc[a + 1] + (VEC[i].we ? T_WR : 1) > ex)
            ex = lg_cyc[a + 1] + (VEC[i].we ? T_WR : 1);
          chk("R6 precharge cmd", (a + 2 < lg_n) ? lg_cmd[a + 2] : 0, 4'b0010);
          chk("R6 precharge single bank", lg_addr[a + 2][10], 0);
          chk("R6 precharge bank", lg_ba[a + 2], VEC[i].ba);
          chk("R6 precharge cycle", lg_cyc[a + 2], ex);
        end else begin
          chk("R7 no explicit precharge",
              (a + 2 < lg_n && lg_cmd[a + 2] == 4'b0010 && !lg_addr[a + 2][10]) ? 1 : 0, 0);
        end
      end
    end

    // ---- back-to-back spacing (R7, R8, R9)
    for (int p = 0; p < 4; p++) begin
      wait_ref();
      repeat (12) @(negedge clk);
      b = lg_n;
      drive(VEC[p]);
      drive(VEC[(p + 1) % 6]);
      repeat (14) @(negedge clk);
      a = find(b, 4'b0011);
      r = (a >= 0) ? find(a + 1, 4'b0011) : -1;
      if (VEC[p].ap) chk("R7 autopre to next activate", (r >= 0) ? lg_cyc[r] - lg_cyc[a] : -1, exp_gap(VEC[p].we));
      else           chk("R8 precharge to next activate", (r >= 0) ? lg_cyc[r] - lg_cyc[a] : -1, exp_gap(VEC[p].we));
    end

    // ---- idle refresh period (R10)
    b = lg_n;
    repeat (3 * T_REFI + 20) @(negedge clk);
    nref = 0;
    r = find(b, 4'b0001);
    while (r >= 0) begin
      int nx;
      nref++;
      chk("R10 precharge-all before refresh", (r > 0 && lg_cmd[r - 1] == 4'b0010) ? lg_addr[r - 1][10] : 0, 1);
      chk("R10 pall spacing", lg_cyc[r] - lg_cyc[r - 1], T_RP);
      nx = find(r + 1, 4'b0001);
      if (nx >= 0) chk("R10 refresh period", lg_cyc[nx] - lg_cyc[r], T_REFI);
      r = nx;
    end
    chk("R10 refreshes in idle window", (nref >= 2) ? 1 : 0, 1);

    // ---- saturating host: refresh still wins (R11, R5)
    b = lg_n;
    n0 = ack_n;
    req_we = 1'b1; req_ap = 1'b0; req_ba = 2'd2; req_row = 13'h0123; req_col = 10'h0aa;
    req_valid = 1'b1;
    repeat (2 * T_REFI) @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    nref = 0;
    nrw = 0;
    for (int k = b; k < lg_n; k++) begin
      if (lg_cmd[k] == 4'b0001) begin
        nref++;
        chk("R11 pall before refresh under load", (lg_cmd[k - 1] == 4'b0010) ? lg_addr[k - 1][10] : 0, 1);
      end
      if (lg_cmd[k] == 4'b0100 || lg_cmd[k] == 4'b0101) nrw++;
    end
    chk("R11 refresh not starved", (nref >= 1) ? 1 : 0, 1);
    chk("R5 ack count under load", ack_n - n0, nrw);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule